// File: doc/BRIEF.md
# Shared-Bus Packet Framer and Display Latch

This block sits behind a byte-level serial receiver on a shared open-drain line. It groups the incoming byte stream into five-byte packets: one header byte, then four data bytes. Every byte seen on the line is taken, including the station's own transmissions, and no packet is filtered by its header. The four data bytes of a packet are copied into display registers only when the packet's last byte arrives, so a half-received packet never reaches the display.

A partial packet is abandoned when the line stays high for too long in the middle of it. The line is sampled on a bit-rate tick, and the run of high samples is counted. When the run reaches the limit while a packet is under way, the bytes gathered so far are dropped and the next byte is treated as a header. A select pulse from a debounced button steps the display output through the four latched data bytes. A one-clock valid pulse marks each display update. The header of the last completed packet is also exposed, both whole and split into its destination and source fields.

Top module: `bus_pkt_rx`

## Requirements
- R1: After reset, `disp_byte`, `disp_idx`, `last_header`, `last_dest`, `last_src` and `pkt_valid` are all zero, and the next byte strobe is taken as a header.
- R2: A packet is five accepted byte strobes. In the clock after the fifth strobe, the display registers hold the four data bytes, and select index k (0..3) shows the (k+1)-th byte after the header.
- R3: `pkt_valid` is high for exactly one clock, the clock in which the new display data first appears.
- R4: On packet completion, `last_header` takes the header byte. `last_dest` is header bits 5..3 and `last_src` is header bits 2..0.
- R5: Any header value completes a packet, including nonzero control bits 7..6 and any destination or source.
- R6: While a packet is incomplete, `pkt_valid` stays low and the display output and `last_header` keep their previous values.
- R7: If `IDLE_BITS` (default 16) consecutive `bit_tick` samples of `line_rx` are high while at least one byte of a packet has been taken, the partial packet is discarded and the next byte strobe is taken as a header.
- R8: A low sample on a tick, or any byte strobe, restarts the high-run count. A shorter run therefore leaves the partial packet intact.
- R9: A high run reaching the limit while no packet is in progress changes no output.
- R10: When the limit is reached in the same clock as a byte strobe mid-packet, the abort wins and that byte is discarded.
- R11: Each `sel_pulse` advances `disp_idx` by one, wrapping from 3 to 0. It does not change the latched data.
- R12: Byte strobes on consecutive clocks are all accepted. After the fifth byte the count wraps, so back-to-back packets each complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | One-clock strobe: a received byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| bit_tick | input | 1 | Bit-rate sampling strobe for the line monitor |
| line_rx | input | 1 | Synchronised level of the shared line |
| sel_pulse | input | 1 | One-clock pulse from the debounced select button |
| disp_byte | output | 8 | Latched data byte at the current select index |
| disp_idx | output | 2 | Current select index |
| pkt_valid | output | 1 | One-clock pulse when the display registers update |
| last_header | output | 8 | Header of the last completed packet |
| last_dest | output | 3 | Destination field of `last_header` |
| last_src | output | 3 | Source field of `last_header` |

## Verification
A byte counter that drifts out of step shows up within one packet. `pkt_valid` rises on the wrong strobe, and the data bytes appear rotated against the select index. A high-run counter that aborts early or fails to abort shows up at the next packet completion, as a missing or misplaced valid pulse. A select counter that wraps wrongly shows the wrong byte on the very next press. Each scenario therefore sends a following packet and checks its alignment.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // modular step: 0,1,..,last,0
  function automatic int wrap_inc(input int v, input int last);
    return (v >= last) ? 0 : v + 1;
  endfunction

  function automatic logic [2:0] hdr_dest(input byte_t h);
    return h[5:3];
  endfunction

  function automatic logic [2:0] hdr_src(input byte_t h);
    return h[2:0];
  endfunction
endpackage

// File: rtl/bpr_idle_timer.sv
module bpr_idle_timer #(
  parameter int IDLE_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic line_rx,
  input  logic activity,
  output logic idle_hit
);
  localparam int CW = $clog2(IDLE_BITS + 1);

  logic [CW-1:0] run_q;

  // fires once, on the sample that completes the high run
  assign idle_hit = bit_tick && line_rx && (run_q == CW'(IDLE_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (activity) begin
      run_q <= '0;
    end else if (bit_tick) begin
      if (!line_rx)                    run_q <= '0;
      else if (run_q != CW'(IDLE_BITS)) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/bpr_framer.sv
module bpr_framer
  import bpr_pkg::*;
#(
  parameter int PKT_BYTES = 5,
  localparam int DATA_N = PKT_BYTES - 1,
  localparam int IDX_W  = $clog2(PKT_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_valid,
  input  byte_t                  byte_data,
  input  logic                   idle_hit,
  output logic [IDX_W-1:0]       idx,
  output logic                   abort_evt,
  output logic                   commit,
  output byte_t                  commit_hdr,
  output byte_t [DATA_N-1:0]     commit_data
);
  localparam int LAST = PKT_BYTES - 1;

  logic [IDX_W-1:0]    idx_q;
  byte_t               hdr_q;
  byte_t [DATA_N-2:0]  stage_q;
  logic                take;

  assign abort_evt = idle_hit && (idx_q != '0);
  assign take      = byte_valid && !abort_evt;
  assign commit    = take && (idx_q == IDX_W'(LAST));
  assign idx       = idx_q;
  assign commit_hdr = hdr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      hdr_q <= '0;
    end else begin
      if (abort_evt)  idx_q <= '0;
      else if (take)  idx_q <= IDX_W'(wrap_inc(int'(idx_q), LAST));
      if (take && idx_q == '0) hdr_q <= byte_data;
    end
  end

  for (genvar k = 0; k < DATA_N - 1; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)                              stage_q[k] <= '0;
      else if (take && idx_q == IDX_W'(k + 1)) stage_q[k] <= byte_data;
    end
    assign commit_data[k] = stage_q[k];
  end
  // last data byte bypasses staging and lands with the commit
  assign commit_data[DATA_N-1] = byte_data;
endmodule

// File: rtl/bpr_display.sv
module bpr_display
  import bpr_pkg::*;
#(
  parameter int DATA_N = 4,
  localparam int SEL_W = $clog2(DATA_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  byte_t              load_hdr,
  input  byte_t [DATA_N-1:0] load_data,
  input  logic               sel_pulse,
  output byte_t [DATA_N-1:0] data_q,
  output byte_t              hdr_q,
  output logic [SEL_W-1:0]   sel_q,
  output logic               valid_q,
  output byte_t              disp_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      hdr_q   <= '0;
      valid_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        data_q <= load_data;
        hdr_q  <= load_hdr;
      end
      if (sel_pulse) sel_q <= SEL_W'(wrap_inc(int'(sel_q), DATA_N - 1));
    end
  end

  assign disp_byte = data_q[sel_q];
endmodule

// File: rtl/bus_pkt_rx.sv
module bus_pkt_rx
  import bpr_pkg::*;
#(
  parameter int PKT_BYTES = 5,
  parameter int IDLE_BITS = 16,
  localparam int DATA_N = PKT_BYTES - 1,
  localparam int IDX_W  = $clog2(PKT_BYTES),
  localparam int SEL_W  = $clog2(DATA_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             bit_tick,
  input  logic             line_rx,
  input  logic             sel_pulse,
  output logic [7:0]       disp_byte,
  output logic [SEL_W-1:0] disp_idx,
  output logic             pkt_valid,
  output logic [7:0]       last_header,
  output logic [2:0]       last_dest,
  output logic [2:0]       last_src
);
  // internal events, named for the checker
  logic               idle_hit;
  logic               abort_evt;
  logic               commit;
  logic [IDX_W-1:0]   idx;
  byte_t              commit_hdr;
  byte_t [DATA_N-1:0] commit_data;
  byte_t [DATA_N-1:0] data_q;

  bpr_idle_timer #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .line_rx  (line_rx),
    .activity (byte_valid),
    .idle_hit (idle_hit)
  );

  bpr_framer #(.PKT_BYTES(PKT_BYTES)) u_frm (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .idle_hit    (idle_hit),
    .idx         (idx),
    .abort_evt   (abort_evt),
    .commit      (commit),
    .commit_hdr  (commit_hdr),
    .commit_data (commit_data)
  );

  bpr_display #(.DATA_N(DATA_N)) u_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (commit),
    .load_hdr  (commit_hdr),
    .load_data (commit_data),
    .sel_pulse (sel_pulse),
    .data_q    (data_q),
    .hdr_q     (last_header),
    .sel_q     (disp_idx),
    .valid_q   (pkt_valid),
    .disp_byte (disp_byte)
  );

  assign last_dest = hdr_dest(last_header);
  assign last_src  = hdr_src(last_header);
endmodule

// File: rtl/bus_pkt_rx_chk.sv
module bus_pkt_rx_chk #(
  parameter int PKT_BYTES = 5,
  parameter int IDX_W = 3,
  parameter int SEL_W = 2,
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_valid,
  input logic             sel_pulse,
  input logic             idle_hit,
  input logic             abort_evt,
  input logic             commit,
  input logic             pkt_valid,
  input logic [IDX_W-1:0] idx,
  input logic [SEL_W-1:0] disp_idx,
  input logic [DW-1:0]    data_q
);
  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(PKT_BYTES - 1));

  assert_valid_follows_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> pkt_valid);

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);

  assert_hold_partial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(data_q));

  assert_abort_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (idx == '0));

  assert_idle_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hit && idx == '0 && !byte_valid) |=> (idx == '0));

  assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_pulse |=> $stable(disp_idx));
endmodule

bind bus_pkt_rx bus_pkt_rx_chk #(
  .PKT_BYTES (PKT_BYTES),
  .IDX_W     (IDX_W),
  .SEL_W     (SEL_W),
  .DW        (DATA_N * 8)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_valid (byte_valid),
  .sel_pulse  (sel_pulse),
  .idle_hit   (idle_hit),
  .abort_evt  (abort_evt),
  .commit     (commit),
  .pkt_valid  (pkt_valid),
  .idx        (idx),
  .disp_idx   (disp_idx),
  .data_q     (data_q)
);

// File: tb/tb_bus_pkt_rx.sv
module tb_bus_pkt_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       bit_tick = 1'b0;
  logic       line_rx = 1'b1;
  logic       sel_pulse = 1'b0;
  logic [7:0] disp_byte;
  logic [1:0] disp_idx;
  logic       pkt_valid;
  logic [7:0] last_header;
  logic [2:0] last_dest;
  logic [2:0] last_src;

  int n_chk = 0;
  int n_bad = 0;
  int exp_sel = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_pkt_rx dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .bit_tick(bit_tick), .line_rx(line_rx), .sel_pulse(sel_pulse),
    .disp_byte(disp_byte), .disp_idx(disp_idx), .pkt_valid(pkt_valid),
    .last_header(last_header), .last_dest(last_dest), .last_src(last_src)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic tick(input logic v);
    @(negedge clk); bit_tick = 1'b1; line_rx = v;
    @(negedge clk); bit_tick = 1'b0; line_rx = 1'b1;
  endtask

  task automatic ticks_high(input int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  task automatic press(input string tag);
    @(negedge clk); sel_pulse = 1'b1;
    @(negedge clk); sel_pulse = 1'b0;
    exp_sel = (exp_sel + 1) % 4;
    check(tag, disp_idx, exp_sel);
  endtask

  // walk all four select positions; data byte k sits at index k
  task automatic check_disp(input string tag, input logic [3:0][7:0] d);
    for (int i = 0; i < 4; i++) begin
      check(tag, disp_byte, d[exp_sel]);
      press({tag, " R11 sel"});
    end
  endtask

  // send bytes from position `from` onward; header is byte 0
  task automatic finish_pkt(input string tag, input int from,
                            input logic [7:0] h, input logic [3:0][7:0] d);
    logic [7:0] prev_disp = disp_byte;
    logic [7:0] prev_hdr  = last_header;
    for (int p = from; p < 5; p++) begin
      send(p == 0 ? h : d[p-1]);
      if (p < 4) begin
        check({tag, " R6 no valid"}, pkt_valid, 0);
        check({tag, " R6 disp hold"}, disp_byte, prev_disp);
        check({tag, " R6 hdr hold"}, last_header, prev_hdr);
      end
    end
    check({tag, " R3 valid"}, pkt_valid, 1);
    check({tag, " R4 header"}, last_header, h);
    check({tag, " R4 dest"}, last_dest, h[5:3]);
    check({tag, " R4 src"}, last_src, h[2:0]);
    @(negedge clk);
    check({tag, " R3 single"}, pkt_valid, 0);
    check_disp({tag, " R2 data"}, d);
  endtask

  task automatic t_reset;
    check("R1 disp", disp_byte, 0);
    check("R1 idx", disp_idx, 0);
    check("R1 valid", pkt_valid, 0);
    check("R1 header", last_header, 0);
    check("R1 dest", last_dest, 0);
    check("R1 src", last_src, 0);
  endtask

  task automatic t_basic;
    finish_pkt("R2 basic", 0, 8'b00_101_011, {8'h44, 8'h33, 8'h22, 8'h11});
  endtask

  task automatic t_nofilter;
    finish_pkt("R5 ctrl", 0, 8'hC0, {8'hD4, 8'hC3, 8'hB2, 8'hA1});
    finish_pkt("R5 all", 0, 8'hFF, {8'h00, 8'hFF, 8'h5A, 8'hA5});
  endtask

  task automatic t_abort;
    send(8'h3A); send(8'h99);
    ticks_high(16);
    finish_pkt("R7 abort", 0, 8'b00_010_110, {8'h04, 8'h03, 8'h02, 8'h01});
  endtask

  task automatic t_short_run;
    send(8'hA1); send(8'h11);
    ticks_high(15); tick(1'b0); ticks_high(15);
    send(8'h12);
    ticks_high(10);
    finish_pkt("R8 short", 3, 8'hA1, {8'h14, 8'h13, 8'h12, 8'h11});
  endtask

  task automatic t_idle_between;
    logic [7:0] h0 = last_header;
    logic [7:0] d0 = disp_byte;
    ticks_high(20);
    check("R9 valid", pkt_valid, 0);
    check("R9 header", last_header, h0);
    check("R9 disp", disp_byte, d0);
    finish_pkt("R9 after", 0, 8'h2D, {8'h88, 8'h77, 8'h66, 8'h55});
  endtask

  task automatic t_collide;
    send(8'h0F); send(8'hEE);
    ticks_high(15);
    @(negedge clk);
    bit_tick = 1'b1; line_rx = 1'b1; byte_valid = 1'b1; byte_data = 8'h77;
    @(negedge clk);
    bit_tick = 1'b0; byte_valid = 1'b0;
    finish_pkt("R10 drop", 0, 8'h1B, {8'hF4, 8'hF3, 8'hF2, 8'hF1});
  endtask

  task automatic t_back2back;
    logic [4:0][7:0] pa = {8'h5D, 8'h5C, 8'h5B, 8'h5A, 8'h09};
    logic [4:0][7:0] pb = {8'h6D, 8'h6C, 8'h6B, 8'h6A, 8'h12};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 5) begin
        check("R12 first valid", pkt_valid, 1);
        check("R12 first hdr", last_header, 8'h09);
        check("R12 first data", disp_byte, pa[exp_sel + 1]);
      end
      if (i == 6) check("R12 gap", pkt_valid, 0);
      byte_valid = 1'b1;
      byte_data = (i < 5) ? pa[i] : pb[i-5];
    end
    @(negedge clk);
    byte_valid = 1'b0;
    check("R12 second valid", pkt_valid, 1);
    check("R12 second hdr", last_header, 8'h12);
    @(negedge clk);
    check_disp("R12 second data", {pb[4], pb[3], pb[2], pb[1]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_nofilter();
    t_abort();
    t_short_run();
    t_idle_between();
    t_collide();
    t_back2back();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule